// File: doc/BRIEF.md
# UART Register Front End with Banked Divisor Access

This block is the bus-facing register layer of a 16550-style serial port. It sits on a simple 32-bit word-addressed bus with address, write enable, read enable, write data and read data. It holds the line, modem, interrupt-enable and power-management settings, returns status supplied by the serial datapath, and sends one-cycle strobes to the transmit path, the receive path and the FIFO controller. The serial shifters, FIFOs, modem pins and interrupt priority logic are outside this block. They appear only as plain input and output ports.

Bit 7 of the line control register is a bank switch. When it is set, the two lowest offsets reach the 16-bit baud divisor instead of the data and interrupt-enable registers. Two further offsets always reach the divisor bytes, whatever the bank bit says. The divisor storage has no reset. After each reset a programmed flag is cleared, and the baud output is held at constant 1 until some divisor byte is written. After that, the baud output carries a one-cycle tick every N clocks for a divisor of N.

Top module: `uart_regbank`

## Requirements
- R1: While rst_n is low at a clock edge, the following are cleared: bus_rdata, ier_o, lcr_o, mcr_o, pwr_o, fcr_o, tx_data_o and all strobes. bus_rdata carries the value of an access in the cycle after the clock edge where bus_rd was high. In every other cycle it is zero.
- R2: With the bank bit (lcr_o[7]) at 0, a read at offset 0x00 returns rx_data_i in bits 7:0 and pulses rx_pop_o for one cycle. A write there loads bus_wdata[7:0] into tx_data_o and pulses tx_load_o for one cycle.
- R3: With the bank bit at 1, offset 0x00 reads and writes the divisor low byte, and offset 0x04 reads and writes the divisor high byte. In this case neither rx_pop_o nor tx_load_o pulses, and ier_o and tx_data_o keep their values.
- R4: With the bank bit at 0, offset 0x04 reads and writes the 8-bit interrupt enable value on ier_o.
- R5: Offset 0x08 reads iid_i. A write there loads bus_wdata[7:0] into fcr_o and pulses fcr_wr_o for one cycle. Both hold for either setting of the bank bit.
- R6: Offsets 0x20 (low byte) and 0x24 (high byte) read and write the divisor for either setting of the bank bit.
- R7: Line control at 0x0C and modem control at 0x10 are 8-bit read/write registers. Power management at 0x30 is a 32-bit read/write register. Offset 0x14 reads lsr_i, and writes to it change nothing.
- R8: Offsets 0x28 and 0x2C return the parameters ID1_VAL and ID2_VAL. Writes to them change nothing.
- R9: Reads of unmapped offsets, including any address with bits 1:0 non-zero, return zero. Writes to them change no output.
- R10: After reset, baud_o stays at 1 in every cycle until a divisor byte is written.
- R11: Once the divisor has been written with a value N that is not 0, baud_o is high for one cycle out of every N and low otherwise. The count restarts at each divisor write, so the first tick comes N-1 cycles after the write edge.
- R12: A programmed divisor of 0 keeps baud_o at 0.
- R13: Reset leaves the divisor value unchanged but clears the programmed state, so R10 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| rx_data_i | input | 8 | Head of the receive path |
| iid_i | input | 8 | Interrupt identification value |
| lsr_i | input | 8 | Line status value |
| tx_data_o | output | 8 | Byte for the transmit path |
| tx_load_o | output | 1 | One-cycle transmit load strobe |
| rx_pop_o | output | 1 | One-cycle receive read strobe |
| fcr_o | output | 8 | FIFO control value |
| fcr_wr_o | output | 1 | One-cycle FIFO control write strobe |
| ier_o | output | 8 | Interrupt enable value |
| lcr_o | output | 8 | Line control value; bit 7 is the bank bit |
| mcr_o | output | 8 | Modem control value |
| pwr_o | output | DATA_W | Power management value |
| baud_o | output | 1 | Baud tick; constant 1 while unprogrammed |

## Verification
The bench switches the bank bit while it accesses the shared offsets. A decoder that ignores the bank bit would send a divisor write to tx_data_o, pulse tx_load_o, or return IER where the divisor byte belongs. The bench writes the divisor through the alias offsets with the bank bit at 0, and then checks the tick phase cycle by cycle. An off-by-one terminal count or a counter that does not restart would show up as a tick in the wrong cycle. A divisor of zero must give no ticks at all. The bench also applies a reset after programming. A design that resets the divisor would return the wrong alias readback, and one that keeps the programmed flag would let baud_o toggle when it must stay at 1.

// File: rtl/uart_rb_pkg.sv
// Shared types and word indices for the UART register front end.
// Assumes a byte-offset bus with 32-bit word spacing.
package uart_rb_pkg;
    localparam int BYTE_W   = 8;
    localparam int BANK_BIT = 7;

    // Word indices (byte offset / 4)
    localparam int WIX_DATA  = 0;
    localparam int WIX_IEDH  = 1;
    localparam int WIX_IDFC  = 2;
    localparam int WIX_LCR   = 3;
    localparam int WIX_MCR   = 4;
    localparam int WIX_LSR   = 5;
    localparam int WIX_DLO   = 8;
    localparam int WIX_DHI   = 9;
    localparam int WIX_ID1   = 10;
    localparam int WIX_ID2   = 11;
    localparam int WIX_PWR   = 12;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIV_LO,
        SEL_DIV_HI,
        SEL_IER,
        SEL_IDFC,
        SEL_LCR,
        SEL_MCR,
        SEL_LSR,
        SEL_ID1,
        SEL_ID2,
        SEL_PWR
    } reg_sel_e;
endpackage

// File: rtl/uart_rb_decode.sv
// Address decoder: maps a byte offset plus the bank bit to one register
// select. Assumes word-aligned accesses; misaligned ones decode as none.
module uart_rb_decode
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank,
    output reg_sel_e          sel
);
    localparam int WIX_W = ADDR_W - 2;

    logic [WIX_W-1:0] wix;
    assign wix = addr[ADDR_W-1:2];

    // Pick the register addressed by this access
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            case (wix)
                WIX_W'(WIX_DATA): sel = bank ? SEL_DIV_LO : SEL_DATA;
                WIX_W'(WIX_IEDH): sel = bank ? SEL_DIV_HI : SEL_IER;
                WIX_W'(WIX_IDFC): sel = SEL_IDFC;
                WIX_W'(WIX_LCR):  sel = SEL_LCR;
                WIX_W'(WIX_MCR):  sel = SEL_MCR;
                WIX_W'(WIX_LSR):  sel = SEL_LSR;
                WIX_W'(WIX_DLO):  sel = SEL_DIV_LO;
                WIX_W'(WIX_DHI):  sel = SEL_DIV_HI;
                WIX_W'(WIX_ID1):  sel = SEL_ID1;
                WIX_W'(WIX_ID2):  sel = SEL_ID2;
                WIX_W'(WIX_PWR):  sel = SEL_PWR;
                default:          sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rb_ctrl.sv
// Control register storage and datapath strobes. All state resets to zero.
// Strobes are registered, so they appear the cycle after the bus access.
module uart_rb_ctrl
    import uart_rb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  reg_sel_e            sel,
    input  logic                wr,
    input  logic                rd,
    input  logic [DATA_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   ier,
    output logic [BYTE_W-1:0]   lcr,
    output logic [BYTE_W-1:0]   mcr,
    output logic [DATA_W-1:0]   pwr,
    output logic [BYTE_W-1:0]   fcr,
    output logic                fcr_wr,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                tx_load,
    output logic                rx_pop
);
    logic [BYTE_W-1:0] wbyte;
    assign wbyte = wdata[BYTE_W-1:0];

    // Hold the writable settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier <= '0;
            lcr <= '0;
            mcr <= '0;
            pwr <= '0;
            fcr <= '0;
            tx_data <= '0;
        end else if (wr) begin
            case (sel)
                SEL_IER:  ier <= wbyte;
                SEL_LCR:  lcr <= wbyte;
                SEL_MCR:  mcr <= wbyte;
                SEL_PWR:  pwr <= wdata;
                SEL_IDFC: fcr <= wbyte;
                SEL_DATA: tx_data <= wbyte;
                default:  ;
            endcase
        end
    end

    // Generate one-cycle strobes toward the datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_load <= 1'b0;
            rx_pop  <= 1'b0;
            fcr_wr  <= 1'b0;
        end else begin
            tx_load <= wr && (sel == SEL_DATA);
            rx_pop  <= rd && (sel == SEL_DATA);
            fcr_wr  <= wr && (sel == SEL_IDFC);
        end
    end

    assert_tx_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(wr && !lcr[BANK_BIT]));
    assert_rx_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(rd && !lcr[BANK_BIT]));
    assert_ier_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lcr[BANK_BIT]) |-> $stable(ier));
    assert_fcr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr |=> !fcr_wr || $past(wr));
endmodule

// File: rtl/uart_rb_divisor.sv
// Baud divisor latch and tick generator. The latch has no reset; a
// programmed flag (reset to 0) holds the output at 1 until any divisor
// byte is written. The count restarts on every divisor write.
module uart_rb_divisor
    import uart_rb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wbyte,
    output logic [2*BYTE_W-1:0] div_q,
    output logic                baud
);
    localparam int DIV_W = 2 * BYTE_W;

    logic             prog_q;
    logic [DIV_W-1:0] cnt_q;
    logic             any_wr;
    logic             at_end;

    assign any_wr = wr_lo || wr_hi;
    assign at_end = (div_q != '0) && (cnt_q == div_q - DIV_W'(1));

    // Latch divisor bytes; intentionally outside reset
    always_ff @(posedge clk) begin
        if (wr_lo) div_q[BYTE_W-1:0]     <= wbyte;
        if (wr_hi) div_q[DIV_W-1:BYTE_W] <= wbyte;
    end

    // Track whether the divisor has been written since reset
    always_ff @(posedge clk) begin
        if (!rst_n)      prog_q <= 1'b0;
        else if (any_wr) prog_q <= 1'b1;
    end

    // Count clocks within one baud period
    always_ff @(posedge clk) begin
        if (!rst_n || any_wr)              cnt_q <= '0;
        else if (prog_q && div_q != '0)    cnt_q <= at_end ? '0 : cnt_q + DIV_W'(1);
    end

    assign baud = !prog_q || (prog_q && at_end);

    assert_prog_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_q |=> prog_q);
    assert_cnt_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_q && div_q != '0) |-> cnt_q < div_q);
    assert_zero_div_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_q && div_q == '0 && !any_wr) |=> !baud);
    assert_div_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_wr) |-> $stable(div_q));
endmodule

// File: rtl/uart_regbank.sv
// Top of the UART register front end: decode, register storage, divisor
// and a registered read multiplexer. Read data appears one cycle after
// bus_rd and is zero otherwise.
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 32,
    parameter logic [31:0]     ID1_VAL = 32'h4455_0102,
    parameter logic [31:0]     ID2_VAL = 32'h0000_0017
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [7:0]          rx_data_i,
    input  logic [7:0]          iid_i,
    input  logic [7:0]          lsr_i,
    output logic [7:0]          tx_data_o,
    output logic                tx_load_o,
    output logic                rx_pop_o,
    output logic [7:0]          fcr_o,
    output logic                fcr_wr_o,
    output logic [7:0]          ier_o,
    output logic [7:0]          lcr_o,
    output logic [7:0]          mcr_o,
    output logic [DATA_W-1:0]   pwr_o,
    output logic                baud_o
);
    reg_sel_e            sel;
    logic [2*BYTE_W-1:0] div_q;
    logic [DATA_W-1:0]   rmux;

    uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .bank (lcr_o[BANK_BIT]),
        .sel  (sel)
    );

    uart_rb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .ier     (ier_o),
        .lcr     (lcr_o),
        .mcr     (mcr_o),
        .pwr     (pwr_o),
        .fcr     (fcr_o),
        .fcr_wr  (fcr_wr_o),
        .tx_data (tx_data_o),
        .tx_load (tx_load_o),
        .rx_pop  (rx_pop_o)
    );

    uart_rb_divisor u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (bus_wr && sel == SEL_DIV_LO),
        .wr_hi (bus_wr && sel == SEL_DIV_HI),
        .wbyte (bus_wdata[BYTE_W-1:0]),
        .div_q (div_q),
        .baud  (baud_o)
    );

    // Select the value returned for the current read
    always_comb begin
        case (sel)
            SEL_DATA:   rmux = DATA_W'(rx_data_i);
            SEL_DIV_LO: rmux = DATA_W'(div_q[BYTE_W-1:0]);
            SEL_DIV_HI: rmux = DATA_W'(div_q[2*BYTE_W-1:BYTE_W]);
            SEL_IER:    rmux = DATA_W'(ier_o);
            SEL_IDFC:   rmux = DATA_W'(iid_i);
            SEL_LCR:    rmux = DATA_W'(lcr_o);
            SEL_MCR:    rmux = DATA_W'(mcr_o);
            SEL_LSR:    rmux = DATA_W'(lsr_i);
            SEL_ID1:    rmux = DATA_W'(ID1_VAL);
            SEL_ID2:    rmux = DATA_W'(ID2_VAL);
            SEL_PWR:    rmux = pwr_o;
            default:    rmux = '0;
        endcase
    end

    // Register read data for one cycle after each read
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_rd) bus_rdata <= '0;
        else                   bus_rdata <= rmux;
    end

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> bus_rdata == '0);
    assert_id1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == ADDR_W'(4 * WIX_ID1)) |-> bus_rdata == DATA_W'(ID1_VAL));
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);
endmodule

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
    localparam logic [31:0] ID1 = 32'h4455_0102;
    localparam logic [31:0] ID2 = 32'h0000_0017;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data_i = 8'hA5, iid_i = 8'hC2, lsr_i = 8'h60;
    logic [7:0]  tx_data_o, fcr_o, ier_o, lcr_o, mcr_o;
    logic        tx_load_o, rx_pop_o, fcr_wr_o, baud_o;
    logic [31:0] pwr_o;

    always #2 clk = ~clk;

    uart_regbank #(.ID1_VAL(ID1), .ID2_VAL(ID2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data_i(rx_data_i), .iid_i(iid_i), .lsr_i(lsr_i),
        .tx_data_o(tx_data_o), .tx_load_o(tx_load_o), .rx_pop_o(rx_pop_o),
        .fcr_o(fcr_o), .fcr_wr_o(fcr_wr_o), .ier_o(ier_o), .lcr_o(lcr_o),
        .mcr_o(mcr_o), .pwr_o(pwr_o), .baud_o(baud_o)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;

    function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    // Scoreboard monitor: compare read data against queued expectations
    always @(posedge clk) pend <= bus_rd;
    always @(negedge clk) begin : mon
        logic [31:0] e;
        string t;
        if (pend) begin
            if (exp_q.size() == 0) chk(0, "R1 unexpected read", bus_rdata, 0);
            else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata == e, t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ok;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk({ier_o, lcr_o, mcr_o, fcr_o, tx_data_o} == '0 && pwr_o == '0, "R1 regs", {ier_o, lcr_o, mcr_o, fcr_o}, 0);
        chk({tx_load_o, rx_pop_o, fcr_wr_o} == 3'b0 && bus_rdata == '0, "R1 strobes/rdata", bus_rdata, 0);
        // R10: baud held at 1 before programming
        ok = 1;
        for (int i = 0; i < 20; i++) begin if (baud_o !== 1'b1) ok = 0; @(negedge clk); end
        chk(ok == 1, "R10 baud high unprogrammed", ok, 1);

        // R2: data path with bank bit 0
        rd(8'h00, 32'hA5, "R2 read rx");
        chk(rx_pop_o == 1'b1, "R2 rx_pop pulse", rx_pop_o, 1);
        @(negedge clk);
        chk(rx_pop_o == 1'b0 && bus_rdata == '0, "R2/R1 pop one cycle, idle zero", bus_rdata, 0);
        wr(8'h00, 32'hFFFF_FF3C);
        chk(tx_load_o == 1'b1 && tx_data_o == 8'h3C, "R2 tx load", tx_data_o, 8'h3C);
        @(negedge clk);
        chk(tx_load_o == 1'b0, "R2 tx_load one cycle", tx_load_o, 0);

        // R4: interrupt enable
        wr(8'h04, 32'h0F);
        rd(8'h04, 32'h0F, "R4 ier readback");
        chk(ier_o == 8'h0F, "R4 ier_o", ier_o, 8'h0F);

        // R7: line, modem, power, status
        wr(8'h0C, 32'h03); rd(8'h0C, 32'h03, "R7 lcr");
        wr(8'h10, 32'h1B); rd(8'h10, 32'h1B, "R7 mcr");
        chk(mcr_o == 8'h1B, "R7 mcr_o", mcr_o, 8'h1B);
        wr(8'h30, 32'hDEAD_ABCD); rd(8'h30, 32'hDEAD_ABCD, "R7 pwr");
        wr(8'h14, 32'hFF); rd(8'h14, 32'h60, "R7 lsr read-only");

        // R5: ident read, fifo control write
        rd(8'h08, 32'hC2, "R5 iid read");
        wr(8'h08, 32'h87);
        chk(fcr_wr_o == 1'b1 && fcr_o == 8'h87, "R5 fcr write", fcr_o, 8'h87);

        // R8: identification constants
        rd(8'h28, ID1, "R8 id1");
        wr(8'h2C, 32'h1234_5678);
        rd(8'h2C, ID2, "R8 id2 after write");

        // R9: unmapped offsets
        rd(8'h18, 0, "R9 unmapped 18");
        rd(8'h34, 0, "R9 unmapped 34");
        rd(8'h0D, 0, "R9 misaligned");
        wr(8'h1C, 32'hFF); wr(8'h0E, 32'hFF);
        chk(ier_o == 8'h0F && lcr_o == 8'h03 && mcr_o == 8'h1B && tx_load_o == 0, "R9 writes ignored", {ier_o, lcr_o, mcr_o}, 32'h0F031B);
        chk(baud_o == 1'b1, "R10 still unprogrammed", baud_o, 1);

        // R3: bank bit set redirects shared offsets
        wr(8'h0C, 32'h83);
        wr(8'h00, 32'h04);
        chk(tx_load_o == 1'b0 && tx_data_o == 8'h3C, "R3 no tx load", tx_data_o, 8'h3C);
        wr(8'h04, 32'h00);
        chk(ier_o == 8'h0F, "R3 ier untouched", ier_o, 8'h0F);
        rd(8'h00, 32'h04, "R3 div lo");
        chk(rx_pop_o == 1'b0, "R3 no rx pop", rx_pop_o, 0);
        rd(8'h04, 32'h00, "R3 div hi");
        rd(8'h20, 32'h04, "R6 alias lo, bank 1");
        rd(8'h08, 32'hC2, "R5 iid with bank 1");
        wr(8'h0C, 32'h03);

        // R6/R11: alias write with bank 0, tick phase
        wr(8'h20, 32'h04);
        ok = 1;
        for (int i = 0; i < 40; i++) begin
            if (baud_o !== ((i % 4) == 3)) begin
                ok = 0;
                chk(0, "R11 tick phase", baud_o, ((i % 4) == 3));
            end
            @(negedge clk);
        end
        chk(ok == 1, "R11 period 4", ok, 1);
        rd(8'h20, 32'h04, "R6 alias lo, bank 0");
        rd(8'h00, 32'hA5, "R6 offset 0 still rx with bank 0");

        // R12: zero divisor
        wr(8'h20, 32'h00);
        ok = 1;
        for (int i = 0; i < 30; i++) begin if (baud_o !== 1'b0) ok = 0; @(negedge clk); end
        chk(ok == 1, "R12 no ticks with zero", ok, 1);

        // R13: reset keeps divisor, clears programmed state
        wr(8'h20, 32'h34); wr(8'h24, 32'h12);
        do_reset();
        ok = 1;
        for (int i = 0; i < 12; i++) begin if (baud_o !== 1'b1) ok = 0; @(negedge clk); end
        chk(ok == 1, "R13 baud high after reset", ok, 1);
        rd(8'h20, 32'h34, "R13 div lo kept");
        rd(8'h24, 32'h12, "R13 div hi kept");
        rd(8'h04, 32'h00, "R13/R1 ier cleared");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all reads observed", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule